// File: doc/BRIEF.md
# Five-Channel Fan Speed Tachometer

This block measures the rotation period of up to five cooling fans. Each fan's tachometer line is brought into the clock domain through a two-stage synchroniser, and its rising edges are detected. The fan is assumed to give two pulses per revolution. A measurement spans one revolution, from a rising edge to the rising edge two pulses later. Over that window a counter advances on a per-channel reference tick. The finished count is stored in a byte-wide register file for host software, which turns the count into revolutions per minute.

All channels share one base tick at nominally 22.5 kHz, derived from the system clock by `CLK_PER_BASE`. Channels 0 to 2 have two modes. In narrow mode the count is 8 bits, saturates at 0xFF, and uses a power-of-two reference divisor chosen per fan; the rate then works out as 1350000 / (count << exponent). In wide mode the count is 16 bits and the reference is half the base rate, so the rate is 675000 / count. Channels 3 and 4 are always wide. A wide count of 0 or 0xFFFF means the fan is stopped or absent.

Measurements run back to back. The edge that ends one window starts the next. A count register changes only when a window completes, when its counter saturates, or when the channel is disabled or reconfigured.

Top module: `fan_tach`

## Requirements
- R1: After reset every register address reads 0x00.
- R2: Address 0 holds the fan enables for channels 0, 1 and 2 in bits 4, 5 and 6. Address 1 holds the enables for channels 3 and 4 in bits 4 and 5, and the wide-mode selects for channels 0, 1 and 2 in bits 0, 1 and 2. Address 2 holds the divisor bits 6:0. All other bits of these three registers read 0. Writes to any count address are ignored.
- R3: Channel i exposes its count low byte at address 4+2i and its high byte at address 5+2i. Address 3 and addresses 14 and 15 read 0x00.
- R4: Tach inputs pass through two synchronising flip-flops. A published count is the number of channel reference ticks strictly between a rising edge and the rising edge two pulses later. The completing edge starts the next window.
- R5: The base tick occurs once every `CLK_PER_BASE` clocks. A wide channel counts every second base tick.
- R6: In narrow mode the reference is the base tick divided by 2^e. Channel 0 takes e from divisor bits 2:0 and channel 1 from bits 5:3. Channel 2 uses e=3 when divisor bit 6 is set and e=1 when it is clear.
- R7: When a counter reaches its all-ones value (0xFF narrow, 0xFFFF wide) before the window completes, that value is published. Counting then waits for the next rising edge to start a new window.
- R8: A disabled channel reads 0x00 in both bytes. When it is re-enabled, nothing is published until a full window after its first rising edge.
- R9: A change of a channel's mode or divisor exponent clears that channel's count to zero and restarts its measurement.
- R10: In narrow mode a channel's high byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_i | input | 5 | Asynchronous tachometer inputs, bit i for channel i |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe, captured on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
The assertions check on every cycle that:
- the register file is clear after reset;
- a write to the fan control register reads back masked on the next cycle;
- unmapped addresses read zero;
- a channel disabled for two cycles holds a zero count;
- a channel that stays in narrow mode never exceeds 0xFF.

Only the bench scenarios can show the following:
- the published counts match the fan period for each reference rate and divisor packing;
- saturation is reached after the expected number of ticks of a stopped fan;
- a re-enabled or reconfigured channel restarts its window.

The bench's cycle model also compares every read against its own prediction.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int NUM_FANS   = 5;
    localparam int NUM_LEGACY = 3;
    localparam int CNT_W      = 16;
    localparam int NARROW_W   = 8;
    localparam int EXP_W      = 3;
    localparam int PRE_W      = (1 << EXP_W) - 1;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_EXT  = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT0 = 4'd4;

    localparam logic [DATA_W-1:0] CTL_MASK = 8'h70;
    localparam logic [DATA_W-1:0] EXT_MASK = 8'h37;
    localparam logic [DATA_W-1:0] DIV_MASK = 8'h7F;

    // wide channels count at half the base rate
    localparam logic [EXP_W-1:0] WIDE_EXP = 3'd1;

    typedef enum logic [1:0] {
        MS_WAIT,    // no window open, waiting for a starting edge
        MS_FIRST,   // window open, mid-revolution edge not yet seen
        MS_SECOND   // mid edge seen, next edge closes the window
    } meas_state_e;

    typedef struct packed {
        logic             en;
        logic             wide;
        logic [EXP_W-1:0] exp;
    } chan_cfg_t;

    // unpacks the three configuration bytes into one channel's settings
    function automatic chan_cfg_t chan_cfg(input int idx,
                                           input logic [DATA_W-1:0] ctl,
                                           input logic [DATA_W-1:0] ext,
                                           input logic [DATA_W-1:0] dv);
        chan_cfg_t c;
        c.en   = 1'b0;
        c.wide = 1'b1;
        c.exp  = WIDE_EXP;
        case (idx)
            0: begin
                c.en   = ctl[4];
                c.wide = ext[0];
                if (!ext[0]) c.exp = dv[2:0];
            end
            1: begin
                c.en   = ctl[5];
                c.wide = ext[1];
                if (!ext[1]) c.exp = dv[5:3];
            end
            2: begin
                c.en   = ctl[6];
                c.wide = ext[2];
                if (!ext[2]) c.exp = dv[6] ? 3'd3 : 3'd1;
            end
            3: c.en = ext[4];
            4: c.en = ext[5];
            default: c.en = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] sat_value(input logic wide);
        return wide ? {CNT_W{1'b1}} : CNT_W'((1 << NARROW_W) - 1);
    endfunction

    function automatic logic [PRE_W-1:0] pre_limit(input logic [EXP_W-1:0] e);
        return PRE_W'((1 << e) - 1);
    endfunction

endpackage

// File: rtl/fan_tach_refgen.sv
module fan_tach_refgen #(
    parameter int DIV = 1467
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/fan_tach_chan.sv
module fan_tach_chan
    import fan_tach_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tach_i,
    input  logic             base_tick_i,
    input  chan_cfg_t        cfg_i,
    output logic [CNT_W-1:0] count_o
);
    logic [2:0]       sync_q;     // [0] first stage, [1] stable, [2] previous
    chan_cfg_t        cfg_q;
    meas_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;

    logic             rise;
    logic             restart;
    logic             ref_tick;
    logic [PRE_W-1:0] lim;
    logic [CNT_W-1:0] top;

    assign rise     = sync_q[1] & ~sync_q[2];
    assign restart  = !cfg_i.en || (cfg_i.wide != cfg_q.wide) || (cfg_i.exp != cfg_q.exp);
    assign lim      = pre_limit(cfg_i.exp);
    assign ref_tick = base_tick_i && (pre_q == lim);
    assign top      = sat_value(cfg_i.wide);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], tach_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= cfg_i;
            state_q <= MS_WAIT;
            cnt_q   <= '0;
            pre_q   <= '0;
            count_o <= '0;
        end else begin
            cfg_q <= cfg_i;
            if (restart) begin
                state_q <= MS_WAIT;
                cnt_q   <= '0;
                pre_q   <= '0;
                count_o <= '0;
            end else begin
                if (base_tick_i) pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
                if (state_q == MS_WAIT) begin
                    if (rise) begin
                        state_q <= MS_FIRST;
                        cnt_q   <= '0;
                    end
                end else if (rise && state_q == MS_SECOND) begin
                    count_o <= cnt_q;
                    cnt_q   <= '0;
                    state_q <= MS_FIRST;
                end else begin
                    if (rise) state_q <= MS_SECOND;
                    if (ref_tick) begin
                        if (cnt_q == top - 1'b1) begin
                            count_o <= top;
                            cnt_q   <= '0;
                            state_q <= MS_WAIT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fan_tach_regs.sv
module fan_tach_regs
    import fan_tach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [CNT_W-1:0]  count_i [NUM_FANS],
    output chan_cfg_t         cfg_o   [NUM_FANS]
);
    logic [DATA_W-1:0] ctl_q, ext_q, div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ext_q <= '0;
            div_q <= '0;
        end else if (we_i) begin
            case (addr_i)
                ADDR_CTL: ctl_q <= wdata_i & CTL_MASK;
                ADDR_EXT: ext_q <= wdata_i & EXT_MASK;
                ADDR_DIV: div_q <= wdata_i & DIV_MASK;
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_cfg
        assign cfg_o[g] = chan_cfg(g, ctl_q, ext_q, div_q);
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTL: rdata_o = ctl_q;
            ADDR_EXT: rdata_o = ext_q;
            ADDR_DIV: rdata_o = div_q;
            default: begin
                for (int i = 0; i < NUM_FANS; i++) begin
                    if (int'(addr_i) == int'(ADDR_CNT0) + 2 * i)
                        rdata_o = count_i[i][DATA_W-1:0];
                    if (int'(addr_i) == int'(ADDR_CNT0) + 2 * i + 1)
                        rdata_o = count_i[i][CNT_W-1:DATA_W];
                end
            end
        endcase
    end
endmodule

// File: rtl/fan_tach.sv
module fan_tach
    import fan_tach_pkg::*;
#(
    parameter int CLK_PER_BASE = 1467
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FANS-1:0] tach_i,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);
    logic             base_tick;
    chan_cfg_t        cfg_w   [NUM_FANS];
    logic [CNT_W-1:0] count_w [NUM_FANS];

    fan_tach_refgen #(.DIV(CLK_PER_BASE)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .tick_o (base_tick)
    );

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_chan
        fan_tach_chan u_chan (
            .clk         (clk),
            .rst         (rst),
            .tach_i      (tach_i[g]),
            .base_tick_i (base_tick),
            .cfg_i       (cfg_w[g]),
            .count_o     (count_w[g])
        );
    end

    fan_tach_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (reg_addr),
        .we_i    (reg_we),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .count_i (count_w),
        .cfg_o   (cfg_w)
    );
endmodule

// File: rtl/fan_tach_chk.sv
module fan_tach_chk
    import fan_tach_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input chan_cfg_t         cfg_w   [NUM_FANS],
    input logic [CNT_W-1:0]  count_w [NUM_FANS]
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reg_rdata == '0)
        else $error("R1: read data not zero right after reset");

    p_ctl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_CTL) |=>
            (reg_addr != ADDR_CTL || reg_rdata == ($past(reg_wdata) & CTL_MASK)))
        else $error("R2: control register did not take the masked write");

    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd3 || int'(reg_addr) >= int'(ADDR_CNT0) + 2 * NUM_FANS) |-> reg_rdata == '0)
        else $error("R3: unmapped address returned data");

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_ch
        p_off_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (!cfg_w[g].en && $past(!cfg_w[g].en)) |-> count_w[g] == '0)
            else $error("R8: disabled channel %0d holds a count", g);

        p_narrow_range_r10: assert property (@(posedge clk) disable iff (rst)
            (!cfg_w[g].wide && $past(!cfg_w[g].wide)) |-> count_w[g][CNT_W-1:NARROW_W] == '0)
            else $error("R10: narrow channel %0d exceeds eight bits", g);
    end
endmodule

bind fan_tach fan_tach_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg_w     (cfg_w),
    .count_w   (count_w)
);

// File: tb/fan_tach_test.sv
`timescale 1ns/1ps
module fan_tach_test;
    localparam int BASE = 3;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic [4:0] tach  = '0;
    logic [3:0] addr  = '0;
    logic       we    = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    always #2.5 clk = ~clk;

    fan_tach #(.CLK_PER_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .tach_i(tach), .reg_addr(addr),
        .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata)
    );

    int errors = 0, checks = 0, shown = 0, rot = 0;
    bit finished = 0;
    int period [5];
    int phase  [5];

    // behavioural reference state
    logic [7:0] m_ctl = 0, m_ext = 0, m_div = 0;
    int m_base = 0;
    bit h1 [5], h2 [5], h3 [5];
    int pre [5], cnt [5], st [5], res [5], pe [5];
    bit pw [5];

    function automatic void cfg_of(input int i, output bit en, output bit wide, output int e);
        en = 0; wide = 1; e = 1;
        case (i)
            0: begin en = m_ctl[4]; wide = m_ext[0]; if (!wide) e = m_div & 7; end
            1: begin en = m_ctl[5]; wide = m_ext[1]; if (!wide) e = (m_div >> 3) & 7; end
            2: begin en = m_ctl[6]; wide = m_ext[2]; if (!wide) e = m_div[6] ? 3 : 1; end
            3: en = m_ext[4];
            default: en = m_ext[5];
        endcase
    endfunction

    function automatic int model_read(input int a);
        if (a == 0) return m_ctl;
        if (a == 1) return m_ext;
        if (a == 2) return m_div;
        if (a >= 4 && a < 14) begin
            if (a % 2 == 0) return res[(a - 4) / 2] & 255;
            return (res[(a - 4) / 2] >> 8) & 255;
        end
        return 0;
    endfunction

    task automatic model_step();
        if (rst) begin
            m_ctl = 0; m_ext = 0; m_div = 0; m_base = 0;
            for (int i = 0; i < 5; i++) begin
                bit en, wide; int e;
                h1[i] = 0; h2[i] = 0; h3[i] = 0;
                pre[i] = 0; cnt[i] = 0; st[i] = 0; res[i] = 0;
                cfg_of(i, en, wide, e);
                pw[i] = wide; pe[i] = e;
            end
        end else begin
            bit tick;
            tick = (m_base == BASE - 1);
            m_base = tick ? 0 : m_base + 1;
            for (int i = 0; i < 5; i++) begin
                bit en, wide, rise, ct; int e, lim, top;
                cfg_of(i, en, wide, e);
                rise = h2[i] && !h3[i];
                h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = tach[i];
                if (!en || wide != pw[i] || e != pe[i]) begin
                    pre[i] = 0; cnt[i] = 0; st[i] = 0; res[i] = 0;
                end else begin
                    lim = (1 << e) - 1;
                    top = wide ? 65535 : 255;
                    ct  = tick && pre[i] == lim;
                    if (tick) pre[i] = (pre[i] == lim) ? 0 : pre[i] + 1;
                    if (st[i] == 0) begin
                        if (rise) begin st[i] = 1; cnt[i] = 0; end
                    end else if (rise && st[i] == 2) begin
                        res[i] = cnt[i]; cnt[i] = 0; st[i] = 1;
                    end else begin
                        if (rise) st[i] = 2;
                        if (ct) begin
                            if (cnt[i] == top - 1) begin res[i] = top; cnt[i] = 0; st[i] = 0; end
                            else cnt[i] = cnt[i] + 1;
                        end
                    end
                end
                pw[i] = wide; pe[i] = e;
            end
            if (we) begin
                case (addr)
                    4'd0: m_ctl = wdata & 8'h70;
                    4'd1: m_ext = wdata & 8'h37;
                    4'd2: m_div = wdata & 8'h7F;
                    default: ;
                endcase
            end
        end
    endtask

    initial forever begin
        @(posedge clk);
        model_step();
    end

    // tachometer generators: half period high, half low; period 0 holds low
    initial begin
        for (int i = 0; i < 5; i++) begin period[i] = 0; phase[i] = 0; end
        forever begin
            @(negedge clk);
            for (int i = 0; i < 5; i++) begin
                if (period[i] == 0) tach[i] = 1'b0;
                else begin
                    tach[i] = (phase[i] < period[i] / 2);
                    phase[i] = (phase[i] + 1) % period[i];
                end
            end
        end
    end

    // every-cycle comparison against the reference model
    initial begin
        wait (rst == 1'b0);
        forever begin
            @(negedge clk);
            #1;
            if (!finished) begin
                checks++;
                if (rdata !== 8'(model_read(int'(addr)))) begin
                    errors++;
                    if (shown < 10)
                        $display("FAIL %s cycle model addr %0d: actual %0h expected %0h",
                                 (addr < 3) ? "R2" : ((addr >= 4 && addr < 14) ? "R4" : "R3"),
                                 addr, rdata, model_read(int'(addr)));
                    shown++;
                end
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 4'(a); wdata = 8'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 4'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic rd_cnt(input int i, output int v);
        int lo, hi, lo2, hi2;
        v = 0;
        for (int k = 0; k < 4; k++) begin
            rd(4 + 2 * i, lo); rd(5 + 2 * i, hi);
            rd(4 + 2 * i, lo2); rd(5 + 2 * i, hi2);
            v = hi * 256 + lo;
            if (lo == lo2 && hi == hi2) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            addr = 4'(rot);
            rot = (rot == 15) ? 0 : rot + 1;
        end
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // window counts land on exp or one short, depending on tick phase
    task automatic near(input string tag, input int got, input int exp);
        checks++;
        if (got != exp && got != exp - 1) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (or one less)", tag, got, exp);
        end
    endtask

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: every address clear after reset
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk("R1 reset read", v, 0);
        end

        // R2: masked configuration registers
        wr(0, 8'hFF); rd(0, v); chk("R2 control mask", v, 8'h70);
        wr(1, 8'hFF); rd(1, v); chk("R2 extended mask", v, 8'h37);
        wr(2, 8'hFF); rd(2, v); chk("R2 divisor mask", v, 8'h7F);

        // narrow ch0 e=0, ch1 e=2, ch2 e=3 (bit 6 set); ch3/ch4 wide
        wr(2, 8'h50);
        wr(1, 8'h30);
        wr(0, 8'h70);
        period[0] = 30; period[1] = 48; period[2] = 96; period[3] = 60; period[4] = 900;
        idle(3200);

        rd_cnt(0, v); near("R5 ch0 narrow e0 base rate", v, 20);
        rd(5, v);     chk("R10 ch0 narrow high byte", v, 0);
        rd_cnt(1, v); near("R6 ch1 exponent from bits 5:3", v, 8);
        rd_cnt(2, v); near("R6 ch2 bit6 set gives divisor 8", v, 8);
        rd_cnt(3, v); near("R5 ch3 wide half base rate", v, 20);
        rd_cnt(4, v); near("R3 ch4 count across both bytes", v, 300);
        rd(12, v);    near("R4 ch4 low byte window", v, 8'h2C);
        rd(3, v);     chk("R3 address 3", v, 0);
        rd(14, v);    chk("R3 address 14", v, 0);
        rd(15, v);    chk("R3 address 15", v, 0);

        // R9: divisor change on ch2 clears, then new rate e=1
        wr(2, 8'h10);
        idle(2);
        rd_cnt(2, v); chk("R9 ch2 cleared on exponent change", v, 0);
        idle(400);
        rd_cnt(2, v); near("R6 ch2 bit6 clear gives divisor 2", v, 32);

        // ch0 to wide mode
        wr(1, 8'h31);
        idle(2);
        rd_cnt(0, v); chk("R9 ch0 cleared on mode change", v, 0);
        idle(200);
        rd_cnt(0, v); near("R5 ch0 wide mode", v, 10);

        // R7: ch1 stops, narrow e=2 saturates after 255 ticks
        period[1] = 0;
        idle(3400);
        rd(6, v); chk("R7 ch1 saturated low byte", v, 255);
        rd(7, v); chk("R10 ch1 saturated high byte", v, 0);
        period[1] = 48;
        idle(300);
        rd_cnt(1, v); near("R4 ch1 measures again after restart", v, 8);

        // R8: disable ch0, writes to count addresses ignored
        wr(0, 8'h60);
        idle(2);
        rd_cnt(0, v); chk("R8 ch0 disabled reads zero", v, 0);
        wr(4, 8'hAA); wr(5, 8'hAA);
        rd_cnt(0, v); chk("R2 count address write ignored", v, 0);
        wr(0, 8'h70);
        idle(20);
        rd(4, v); chk("R8 nothing published before a full window", v, 0);
        idle(200);
        rd_cnt(0, v); near("R8 ch0 counts after re-enable", v, 10);

        idle(10);
        summary();
    end
endmodule